// File: doc/BRIEF.md
# Serial Memory Status and Protection Unit

This block holds the status byte of a small serial nonvolatile memory and decides, cycle by cycle, whether an array write to a given 9-bit address may go ahead. An external SPI mode-0 shifter collects the instruction byte and, for the status write, the data byte. It then presents both here as a one-cycle command strobe. The array controller raises a start strobe when it wants to begin an internal write cycle and a done strobe when that cycle ends.

The status byte is always visible as a combinational view of the stored state, so the shifter can send it out at any time, including in the middle of a write cycle. The two protect bits stand for retained storage: a reset does not touch them, while the busy flag and the enable latch return to zero.

Top module: `nvs_status_unit`

## Requirements
- R1: `status_byte` carries busy in bit 0, the enable latch in bit 1, the low protect bit in bit 2 and the high protect bit in bit 3. Bits 7 to 4 always read 0.
- R2: An accepted `wr_start` sets busy. A start is accepted only in a cycle where `write_ok` is 1. `wr_done` clears busy. The status-write data byte never changes busy.
- R3: Opcode 05h (status read) and any opcode other than 01h, 04h and 06h leave busy, the latch and the protect bits unchanged.
- R4: Opcode 06h sets the enable latch and opcode 04h clears it. Both act whatever the protect bits hold and whether or not busy is 1.
- R5: Opcode 01h with the latch at 1 and busy at 0 loads the protect bits from `cmd_data[3:2]` and clears the latch. With the latch at 0 or busy at 1 it changes nothing. The other data bits are ignored.
- R6: `write_ok` is 1 exactly when the latch is 1, busy is 0 and `chk_addr` lies outside the protected window.
- R7: The protect bits select the protected window: 00 protects nothing, 01 protects 180h–1FFh, 10 protects 100h–1FFh, 11 protects 000h–1FFh.
- R8: `wr_done` clears the enable latch.
- R9: Reset sets busy and the latch to 0 and keeps the protect bits unchanged.
- R10: While busy is 1, `status_byte` still shows the current latch and protect bits, and a 06h or 04h issued then is reflected in it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle strobe: a decoded command is present |
| cmd_op | input | 8 | Instruction byte |
| cmd_data | input | 8 | Data byte for the status write |
| wr_start | input | 1 | Request to begin an internal array write cycle |
| wr_done | input | 1 | The internal write cycle has finished |
| chk_addr | input | 9 | Target address for the write-permission query |
| status_byte | output | 8 | Status byte for shifting out |
| write_ok | output | 1 | An array write to `chk_addr` is permitted now |

## Verification
Every state change (busy, latch, protect bits) is due one clock edge after the strobe that causes it and appears on `status_byte` in that cycle. `write_ok` reacts in the same cycle to a change of `chk_addr`, and after one edge to a change of state. The bench drives each stimulus on a falling edge and compares both outputs one time unit later against a model advanced once per rising edge. Each comparison therefore sees the state left by all earlier edges together with the present address.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

    typedef enum logic [7:0] {
        OP_SET_STAT = 8'h01,
        OP_LATCH_OFF = 8'h04,
        OP_GET_STAT = 8'h05,
        OP_LATCH_ON = 8'h06
    } nvs_op_e;

    typedef struct packed {
        logic [3:0] spare;
        logic [1:0] guard;
        logic       latch;
        logic       busy;
    } nvs_stat_s;

    typedef struct packed {
        logic latch_on;
        logic latch_off;
        logic set_stat;
    } nvs_cmd_s;

    // Segment index is the top two address bits; guard code picks how many
    // upper segments are locked (0, 1, 2 or all 4).
    function automatic logic seg_locked(input logic [1:0] guard, input logic [1:0] seg);
        logic r;
        case (guard)
            2'b00:   r = 1'b0;
            2'b01:   r = (seg == 2'b11);
            2'b10:   r = seg[1];
            default: r = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/nvs_cmd_dec.sv
module nvs_cmd_dec
    import nvs_pkg::*;
(
    input  logic       cmd_valid,
    input  logic [7:0] cmd_op,
    output nvs_cmd_s   cmd
);
    always_comb begin
        cmd = '0;
        if (cmd_valid) begin
            case (cmd_op)
                OP_LATCH_ON:  cmd.latch_on  = 1'b1;
                OP_LATCH_OFF: cmd.latch_off = 1'b1;
                OP_SET_STAT:  cmd.set_stat  = 1'b1;
                default:      cmd = '0;
            endcase
        end
    end
endmodule

// File: rtl/nvs_state_regs.sv
module nvs_state_regs
    import nvs_pkg::*;
#(
    parameter logic [1:0] GUARD_INIT = 2'b00
) (
    input  logic       clk,
    input  logic       rst,
    input  nvs_cmd_s   cmd,
    input  logic [1:0] guard_new,
    input  logic       start_acc,
    input  logic       cycle_end,
    output logic       latch_q,
    output logic       busy_q,
    output logic [1:0] guard_q
);
    logic stat_acc;

    assign stat_acc = cmd.set_stat && latch_q && !busy_q;

    // retained bits: no reset term
    logic [1:0] guard_r = GUARD_INIT;
    always_ff @(posedge clk) begin
        if (stat_acc) guard_r <= guard_new;
    end
    assign guard_q = guard_r;

    always_ff @(posedge clk) begin
        if (rst)                        latch_q <= 1'b0;
        else if (cmd.latch_on)          latch_q <= 1'b1;
        else if (cmd.latch_off)         latch_q <= 1'b0;
        else if (stat_acc || cycle_end) latch_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)            busy_q <= 1'b0;
        else if (start_acc) busy_q <= 1'b1;
        else if (cycle_end) busy_q <= 1'b0;
    end
endmodule

// File: rtl/nvs_guard_decode.sv
module nvs_guard_decode
    import nvs_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        guard,
    output logic              locked
);
    localparam int SEG_HI = ADDR_W - 1;
    localparam int SEG_LO = ADDR_W - 2;

    assign locked = seg_locked(guard, addr[SEG_HI:SEG_LO]);
endmodule

// File: rtl/nvs_status_unit.sv
module nvs_status_unit
    import nvs_pkg::*;
#(
    parameter int         ADDR_W     = 9,
    parameter logic [1:0] GUARD_INIT = 2'b00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_op,
    input  logic [7:0]        cmd_data,
    input  logic              wr_start,
    input  logic              wr_done,
    input  logic [ADDR_W-1:0] chk_addr,
    output logic [7:0]        status_byte,
    output logic              write_ok
);
    localparam int GUARD_LSB = 2;

    nvs_cmd_s   cmd;
    nvs_stat_s  stat;
    logic       latch_q, busy_q, locked;
    logic [1:0] guard_q;

    nvs_cmd_dec u_dec (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd       (cmd)
    );

    nvs_state_regs #(.GUARD_INIT(GUARD_INIT)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .guard_new (cmd_data[GUARD_LSB +: 2]),
        .start_acc (wr_start && write_ok),
        .cycle_end (wr_done),
        .latch_q   (latch_q),
        .busy_q    (busy_q),
        .guard_q   (guard_q)
    );

    nvs_guard_decode #(.ADDR_W(ADDR_W)) u_guard (
        .addr   (chk_addr),
        .guard  (guard_q),
        .locked (locked)
    );

    always_comb begin
        stat       = '0;
        stat.busy  = busy_q;
        stat.latch = latch_q;
        stat.guard = guard_q;
    end

    assign status_byte = stat;
    assign write_ok    = latch_q && !busy_q && !locked;
endmodule

// File: rtl/nvs_status_chk.sv
module nvs_status_chk #(
    parameter int ADDR_W = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic [7:0]        cmd_op,
    input logic [7:0]        cmd_data,
    input logic              wr_start,
    input logic              wr_done,
    input logic [ADDR_W-1:0] chk_addr,
    input logic [7:0]        status_byte,
    input logic              write_ok
);
    AST_LATCH_ON: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 8'h06) |=> status_byte[1]); // R4
    AST_LATCH_OFF: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 8'h04) |=> !status_byte[1]); // R4
    AST_BUSY_SET: assert property (@(posedge clk) disable iff (rst)
        (wr_start && write_ok) |=> status_byte[0]); // R2
    AST_BUSY_CLR: assert property (@(posedge clk) disable iff (rst)
        (wr_done && !wr_start) |=> !status_byte[0]); // R2
    AST_DONE_LATCH: assert property (@(posedge clk) disable iff (rst)
        (wr_done && !(cmd_valid && cmd_op == 8'h06)) |=> !status_byte[1]); // R8
    AST_OK_GATED: assert property (@(posedge clk) disable iff (rst)
        write_ok |-> (status_byte[1] && !status_byte[0])); // R6
    AST_GUARD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(cmd_valid && cmd_op == 8'h01) |=> $stable(status_byte[3:2])); // R5
    AST_GUARD_LOCKED_OUT: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 8'h01 && !status_byte[1]) |=> $stable(status_byte[3:2])); // R5
    AST_FULL_LOCK: assert property (@(posedge clk) disable iff (rst)
        (status_byte[3:2] == 2'b11) |-> !write_ok); // R7
endmodule

bind nvs_status_unit nvs_status_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_nvs_status_unit.sv
module sim_nvs_status_unit;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_op = '0;
    logic [7:0] cmd_data = '0;
    logic       wr_start = 1'b0;
    logic       wr_done = 1'b0;
    logic [8:0] chk_addr = '0;
    logic [7:0] status_byte;
    logic       write_ok;

    int n_chk = 0;
    int n_bad = 0;

    logic       m_busy = 1'b0;
    logic       m_latch = 1'b0;
    logic [1:0] m_guard = 2'b00;

    always #(CLK_PERIOD/2) clk = ~clk;

    nvs_status_unit u0 (.*);

    function automatic logic in_window(input logic [1:0] g, input logic [8:0] a);
        case (g)
            2'b00:   return 1'b0;
            2'b01:   return a >= 9'h180;
            2'b10:   return a >= 9'h100;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [7:0] exp_status();
        return {4'b0000, m_guard, m_latch, m_busy};
    endfunction

    task automatic check(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // drive one cycle, compare outputs against model, then advance the model
    task automatic step(input logic v, input logic [7:0] op, input logic [7:0] d,
                        input logic st, input logic dn, input logic [8:0] a, input string tag);
        logic ok_exp;
        @(negedge clk);
        cmd_valid = v; cmd_op = op; cmd_data = d;
        wr_start = st; wr_done = dn; chk_addr = a;
        #1;
        ok_exp = m_latch && !m_busy && !in_window(m_guard, a);
        check(status_byte == exp_status(), {tag, " R1 status"}, status_byte, exp_status());
        check(write_ok == ok_exp, {tag, " R6 write_ok"}, {7'd0, write_ok}, {7'd0, ok_exp});
        begin
            logic set_acc;
            set_acc = v && op == 8'h01 && m_latch && !m_busy;
            if (set_acc) m_guard = d[3:2];
            if (st && ok_exp) m_busy = 1'b1;
            else if (dn) m_busy = 1'b0;
            if (v && op == 8'h06) m_latch = 1'b1;
            else if (v && op == 8'h04) m_latch = 1'b0;
            else if (set_acc || dn) m_latch = 1'b0;
        end
    endtask

    task automatic idle(input logic [8:0] a, input string tag);
        step(1'b0, 8'h00, 8'h00, 1'b0, 1'b0, a, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cmd_valid = 1'b0; wr_start = 1'b0; wr_done = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        m_busy = 1'b0; m_latch = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd4711));
        do_reset();
        // R9 reset state, R1 layout
        #1 check(status_byte == 8'h00, "R9 reset status", status_byte, 8'h00);

        // R5 status write ignored with latch clear
        step(1'b1, 8'h01, 8'hFF, 0, 0, 9'h000, "R5 locked-out write");
        idle(9'h000, "R5 after ignored");
        // R4 latch on, R5 accepted write of guard 01, upper data bits ignored
        step(1'b1, 8'h06, 8'h00, 0, 0, 9'h000, "R4 latch on");
        step(1'b1, 8'h01, 8'hF7, 0, 0, 9'h17F, "R5 set guard 01");
        idle(9'h17F, "R5 latch cleared");
        // R7 window edges with latch on
        step(1'b1, 8'h06, 8'h00, 0, 0, 9'h17F, "R4 latch on");
        idle(9'h17F, "R7 below 180h");
        idle(9'h180, "R7 at 180h");
        idle(9'h1FF, "R7 top");
        // R3 status read and unknown opcodes change nothing
        step(1'b1, 8'h05, 8'hFF, 0, 0, 9'h000, "R3 status read");
        step(1'b1, 8'hA5, 8'hFF, 0, 0, 9'h000, "R3 unknown op");
        step(1'b1, 8'h02, 8'hFF, 0, 0, 9'h000, "R3 unknown op");
        idle(9'h000, "R3 after");
        // R2 start, R10 status during busy, R4 latch changes while busy
        step(1'b0, 8'h00, 8'h00, 1, 0, 9'h010, "R2 start");
        idle(9'h010, "R10 busy visible");
        step(1'b1, 8'h01, 8'h0C, 0, 0, 9'h010, "R5 ignored while busy");
        step(1'b1, 8'h06, 8'h00, 0, 0, 9'h010, "R10 latch on while busy");
        step(1'b1, 8'h04, 8'h00, 0, 0, 9'h010, "R10 latch off while busy");
        step(1'b1, 8'h06, 8'h00, 0, 0, 9'h010, "R4 latch on while busy");
        step(1'b0, 8'h00, 8'h00, 0, 1, 9'h010, "R8 done");
        idle(9'h010, "R8 latch cleared by done");
        // R2 start refused in protected window
        step(1'b1, 8'h06, 8'h00, 0, 0, 9'h1C0, "R4 latch on");
        step(1'b0, 8'h00, 8'h00, 1, 0, 9'h1C0, "R2 refused start");
        idle(9'h1C0, "R2 still idle");
        // guard 11 then R4 under full lock, R9 retention
        step(1'b1, 8'h01, 8'h0C, 0, 0, 9'h000, "R5 set guard 11");
        step(1'b1, 8'h06, 8'h00, 0, 0, 9'h000, "R4 latch on under full lock");
        idle(9'h000, "R7 all locked");
        do_reset();
        #1 check(status_byte == 8'h0C, "R9 guard kept over reset", status_byte, 8'h0C);
        // guard 10 window edges
        step(1'b1, 8'h06, 8'h00, 0, 0, 9'h0FF, "R4 latch on");
        step(1'b1, 8'h01, 8'h08, 0, 0, 9'h0FF, "R5 set guard 10");
        step(1'b1, 8'h06, 8'h00, 0, 0, 9'h0FF, "R4 latch on");
        idle(9'h0FF, "R7 below 100h");
        idle(9'h100, "R7 at 100h");

        // constrained random, one event per cycle
        for (int i = 0; i < 4000; i++) begin
            logic [8:0] a;
            logic [7:0] op, d;
            int k;
            case ($urandom % 8)
                0: a = 9'h0FF; 1: a = 9'h100; 2: a = 9'h17F; 3: a = 9'h180;
                4: a = 9'h1FF; 5: a = 9'h000;
                default: a = 9'($urandom);
            endcase
            d = 8'($urandom);
            case ($urandom % 6)
                0: op = 8'h01; 1: op = 8'h04; 2: op = 8'h05; 3: op = 8'h06;
                4: op = 8'($urandom); default: op = 8'h06;
            endcase
            k = $urandom % 4;
            if (i % 500 == 250) do_reset();
            case (k)
                0: step(1'b1, op, d, 0, 0, a, "rand cmd");
                1: step(1'b0, 8'h00, d, 1, 0, a, "rand start");
                2: step(1'b0, 8'h00, d, 0, m_busy, a, "rand done");
                default: idle(a, "rand idle");
            endcase
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule